// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-to-physical page translations. Each slot holds a translation for either a 4KB page or a 2MB page. It also records the 12-bit context identifier that was active when the translation was installed, and a global flag. A lookup presents a 48-bit virtual address. In the same cycle the block returns hit or miss, and on a hit it returns the 40-bit physical address and the permission bits. On a miss it raises a walk request so that an external page walker can fetch the translation and install it through the fill port.

A control port carries three operations. A root switch loads a new active context identifier, which software takes from the low 12 bits of its root pointer value, and carries a keep flag. With the keep flag set, every slot survives and slots of other contexts simply stop matching. With the keep flag clear, every non-global slot is dropped. The other two operations are an invalidate of one virtual page and a full flush. Lookups always compare against the context loaded by the last root switch.

The lookup port has a valid strobe and no ready, because every lookup is answered in the same cycle. The fill port is valid/ready. A fill is taken on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low in any cycle that carries a control operation, and the control operation takes that cycle. A fill held valid while not ready is kept waiting by the source.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every slot is empty and the active context is 0, so every lookup misses, and `fill_ready` is high.
- R2: A valid lookup that matches a 4KB slot raises `lk_hit` in the same cycle. `lk_pa` is then {slot frame number, va[11:0]} and `lk_perm` is the slot's permissions. A valid lookup that matches no slot raises `walk_req`, and `walk_req` is never high together with `lk_hit`.
- R3: A 2MB slot (`fill_big`=1) matches on va[47:21] only. It returns `lk_pa` = {frame number bits [27:9], va[20:0]}, so it covers 512 times the range of a 4KB slot, which matches on va[47:12].
- R4: A slot hits only when its recorded context equals the active context or its global flag is set.
- R5: A root switch (`ctl_op`=1) with `ctl_keep`=1 loads `ctl_ctx` as the active context and keeps every slot. Returning to an earlier context makes its slots hit again.
- R6: A root switch with `ctl_keep`=0 loads the new context, drops every non-global slot and keeps global slots.
- R7: A page invalidate (`ctl_op`=2, page number `ctl_vpn` = va[47:12]) drops every slot of either size that covers that page and belongs to the active context or is global. Slots of other contexts and slots for other pages stay.
- R8: A full flush (`ctl_op`=3) drops every slot, global ones included.
- R9: `fill_ready` is low exactly in cycles where `ctl_op` is not 0. An accepted fill records the active context.
- R10: A fill whose range overlaps a visible valid slot (same context, or global on either side) replaces it, so at most one slot ever hits one address, and the lookup returns the newest translation.
- R11: A fill with no overlap takes the lowest-numbered empty slot. When every slot is full it takes the slot under a round-robin pointer. The pointer starts at 0 and advances by one after each such eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 40 | Physical address on a hit |
| lk_perm | output | 4 | Permission bits on a hit |
| walk_req | output | 1 | Miss: request a page walk |
| fill_valid | input | 1 | Fill strobe |
| fill_ready | output | 1 | Fill accepted this cycle if valid |
| fill_vpn | input | 36 | Virtual page number va[47:12] of the fill |
| fill_ppn | input | 28 | Physical frame number pa[39:12] |
| fill_big | input | 1 | 1 = 2MB page, 0 = 4KB page |
| fill_glob | input | 1 | Global flag |
| fill_perm | input | 4 | Permission bits |
| ctl_op | input | 2 | 0 none, 1 root switch, 2 page invalidate, 3 full flush |
| ctl_ctx | input | 12 | New context on a root switch (low 12 bits of the root value) |
| ctl_keep | input | 1 | Root switch keeps all slots |
| ctl_vpn | input | 36 | Page number va[47:12] for a page invalidate |

## Verification
The bench fills all sixteen slots with distinct 4KB pages and reads each back at several offsets. It then overfills the array: a design that ignored empty slots or did not advance its victim pointer would evict the wrong page. The 2MB checks sweep offsets inside and outside the 2MB range, which catches a slot that compares too many or too few address bits, or that splices the physical address at bit 12. Context tests switch between contexts with and without the keep flag. A design that dropped global slots, or kept stale non-global ones, would give wrong hits on return. Invalidate tests hit a 2MB slot through an inner page, a global slot, and a slot of another context. A design that matched on the wrong size or ignored context would remove the wrong slot or miss the right one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 48;
  localparam int PA_W     = 40;
  localparam int CTX_W    = 12;
  localparam int PERM_W   = 4;
  localparam int SMALL_SH = 12;
  localparam int BIG_SH   = 21;
  localparam int VPN_W    = VA_W - SMALL_SH;
  localparam int PPN_W    = PA_W - SMALL_SH;
  localparam int BIG_LO   = BIG_SH - SMALL_SH;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ROOT  = 2'd1,
    OP_INVPG = 2'd2,
    OP_FLUSH = 2'd3
  } ctl_op_e;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic              big;
    logic [CTX_W-1:0]  ctx;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
  import tlb_pkg::*;
(
  input  logic             e_valid,
  input  logic             e_glob,
  input  logic             e_big,
  input  logic [CTX_W-1:0] e_ctx,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic             q_wide,
  input  logic             q_any_ctx,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             match
);
  logic [VPN_W-1:0] mask;
  logic             seen;

  always_comb begin
    mask = '1;
    if (e_big || q_wide) mask[BIG_LO-1:0] = '0;
    seen  = e_glob || q_any_ctx || (e_ctx == q_ctx);
    match = e_valid && seen && (((e_vpn ^ q_vpn) & mask) == '0);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_vec,
  input  logic [N-1:0]  ovl_vec,
  input  logic [IW-1:0] rr,
  output logic [IW-1:0] idx,
  output logic          use_rr
);
  always_comb begin
    idx = rr;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) idx = IW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (ovl_vec[i]) idx = IW'(i);
    end
    use_rr = (ovl_vec == '0) && (&valid_vec);
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PERM_W-1:0] lk_perm,
  output logic              walk_req,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_big,
  input  logic              fill_glob,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic [1:0]        ctl_op,
  input  logic [CTX_W-1:0]  ctl_ctx,
  input  logic              ctl_keep,
  input  logic [VPN_W-1:0]  ctl_vpn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t           tbl [ENTRIES];
  logic [CTX_W-1:0]   cur_ctx;
  logic [IW-1:0]      rr;
  logic [ENTRIES-1:0] hit_vec, inv_vec, ovl_vec, valid_vec, glob_vec;
  logic [IW-1:0]      vict;
  logic               use_rr;
  tlb_ent_t           sel;
  logic               fill_fire;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign valid_vec[g] = tbl[g].valid;
    assign glob_vec[g]  = tbl[g].glob;

    tlb_cmp u_look (
      .e_valid(tbl[g].valid), .e_glob(tbl[g].glob), .e_big(tbl[g].big),
      .e_ctx(tbl[g].ctx), .e_vpn(tbl[g].vpn),
      .q_vpn(lk_va[VA_W-1:SMALL_SH]), .q_wide(1'b0), .q_any_ctx(1'b0),
      .q_ctx(cur_ctx), .match(hit_vec[g])
    );
    tlb_cmp u_inv (
      .e_valid(tbl[g].valid), .e_glob(tbl[g].glob), .e_big(tbl[g].big),
      .e_ctx(tbl[g].ctx), .e_vpn(tbl[g].vpn),
      .q_vpn(ctl_vpn), .q_wide(1'b0), .q_any_ctx(1'b0),
      .q_ctx(cur_ctx), .match(inv_vec[g])
    );
    tlb_cmp u_ovl (
      .e_valid(tbl[g].valid), .e_glob(tbl[g].glob), .e_big(tbl[g].big),
      .e_ctx(tbl[g].ctx), .e_vpn(tbl[g].vpn),
      .q_vpn(fill_vpn), .q_wide(fill_big), .q_any_ctx(fill_glob),
      .q_ctx(cur_ctx), .match(ovl_vec[g])
    );
  end

  tlb_victim #(.N(ENTRIES)) u_vict (
    .valid_vec(valid_vec), .ovl_vec(ovl_vec), .rr(rr),
    .idx(vict), .use_rr(use_rr)
  );

  // Lookup result: hits are one-hot, so an OR-reduction selects the slot.
  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) sel = sel | tbl[i];
    end
    lk_hit   = lk_valid && (hit_vec != '0);
    walk_req = lk_valid && (hit_vec == '0);
    lk_perm  = sel.perm;
    if (sel.big) lk_pa = {sel.ppn[PPN_W-1:BIG_LO], lk_va[BIG_SH-1:0]};
    else         lk_pa = {sel.ppn, lk_va[SMALL_SH-1:0]};
  end

  assign fill_ready = (ctl_op == OP_NONE);
  assign fill_fire  = fill_valid && fill_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      cur_ctx <= '0;
      rr      <= '0;
    end else begin
      case (ctl_op_e'(ctl_op))
        OP_ROOT: begin
          cur_ctx <= ctl_ctx;
          if (!ctl_keep) begin
            for (int i = 0; i < ENTRIES; i++)
              if (!tbl[i].glob) tbl[i].valid <= 1'b0;
          end
        end
        OP_INVPG: begin
          for (int i = 0; i < ENTRIES; i++)
            if (inv_vec[i]) tbl[i].valid <= 1'b0;
        end
        OP_FLUSH: begin
          for (int i = 0; i < ENTRIES; i++) tbl[i].valid <= 1'b0;
        end
        default: begin
          if (fill_fire) begin
            for (int i = 0; i < ENTRIES; i++)
              if (ovl_vec[i]) tbl[i].valid <= 1'b0;
            tbl[vict] <= '{valid: 1'b1, glob: fill_glob, big: fill_big,
                           ctx: cur_ctx, vpn: fill_vpn, ppn: fill_ppn,
                           perm: fill_perm};
            if (use_rr) rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               walk_req,
  input logic               fill_ready,
  input logic [1:0]         ctl_op,
  input logic               ctl_keep,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] glob_vec
);
  p_walk_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> walk_req);

  p_no_walk_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !walk_req);

  p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_ctl_blocks_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op != OP_NONE) |-> !fill_ready);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == OP_FLUSH) |=> (hit_vec == '0));

  p_switch_drops_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == OP_ROOT && !ctl_keep) |=> ((hit_vec & ~glob_vec) == '0));
endmodule

bind ctx_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .walk_req(walk_req), .fill_ready(fill_ready), .ctl_op(ctl_op),
  .ctl_keep(ctl_keep), .hit_vec(hit_vec), .glob_vec(glob_vec)
);

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  import tlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0;
  logic [VA_W-1:0]   lk_va = '0;
  logic              lk_hit, walk_req, fill_ready;
  logic [PA_W-1:0]   lk_pa;
  logic [PERM_W-1:0] lk_perm;
  logic              fill_valid = 1'b0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic              fill_big = 1'b0, fill_glob = 1'b0;
  logic [PERM_W-1:0] fill_perm = '0;
  logic [1:0]        ctl_op = 2'd0;
  logic [CTX_W-1:0]  ctl_ctx = '0;
  logic              ctl_keep = 1'b0;
  logic [VPN_W-1:0]  ctl_vpn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctx_tlb u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] exp_pa(input logic [PPN_W-1:0] ppn,
                                             input bit big, input logic [VA_W-1:0] va);
    if (big) return {ppn[PPN_W-1:BIG_LO], va[BIG_SH-1:0]};
    return {ppn, va[SMALL_SH-1:0]};
  endfunction

  task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input bit big, input bit glob, input logic [PERM_W-1:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_big = big; fill_glob = glob; fill_perm = perm;
    #1 chk(fill_ready == 1'b1, "R9 ready idle", 64'(fill_ready), 64'd1);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_ctl(input logic [1:0] op, input logic [CTX_W-1:0] ctx,
                        input bit keep, input logic [VPN_W-1:0] vpn);
    @(negedge clk);
    ctl_op = op; ctl_ctx = ctx; ctl_keep = keep; ctl_vpn = vpn;
    #1 chk(fill_ready == 1'b0, "R9 ready low on ctl", 64'(fill_ready), 64'd0);
    @(negedge clk);
    ctl_op = 2'd0;
  endtask

  // Lookup that expects a hit with a known translation.
  task automatic look_hit(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] ppn,
                          input bit big, input logic [PERM_W-1:0] perm, input string req);
    lk_valid = 1'b1; lk_va = va;
    #1;
    chk(lk_hit === 1'b1 && walk_req === 1'b0, {req, " hit"}, 64'(lk_hit), 64'd1);
    chk(lk_pa === exp_pa(ppn, big, va), {req, " pa"}, 64'(lk_pa), 64'(exp_pa(ppn, big, va)));
    chk(lk_perm === perm, {req, " perm"}, 64'(lk_perm), 64'(perm));
    lk_valid = 1'b0;
  endtask

  task automatic look_miss(input logic [VA_W-1:0] va, input string req);
    lk_valid = 1'b1; lk_va = va;
    #1;
    chk(lk_hit === 1'b0 && walk_req === 1'b1, {req, " miss"}, 64'(lk_hit), 64'd0);
    lk_valid = 1'b0;
  endtask

  function automatic logic [VPN_W-1:0] pg(input int i);
    return VPN_W'(36'h1000 + i * 37);
  endfunction

  function automatic logic [PPN_W-1:0] fr(input int i);
    return PPN_W'(28'h100 + i * 3);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    #1 chk(fill_ready == 1'b1, "R1 ready", 64'(fill_ready), 64'd1);
    look_miss({pg(0), 12'h000}, "R1");
    look_miss({36'h0, 12'h000}, "R1");

    // R2 and R11: fill every slot with a 4KB page, read back at offsets
    for (int i = 0; i < 16; i++) do_fill(pg(i), fr(i), 1'b0, 1'b0, 4'(i));
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      look_hit({pg(i), 12'h000}, fr(i), 1'b0, 4'(i), "R2");
      look_hit({pg(i), 12'hfff}, fr(i), 1'b0, 4'(i), "R2");
      look_hit({pg(i), 12'(i * 251)}, fr(i), 1'b0, 4'(i), "R2");
    end
    look_miss({pg(16), 12'h010}, "R2");

    // R11: full array evicts in round-robin order starting at slot 0
    do_fill(pg(16), fr(16), 1'b0, 1'b0, 4'h1);
    look_miss({pg(0), 12'h0}, "R11");
    look_hit({pg(1), 12'h0}, fr(1), 1'b0, 4'd1, "R11");
    look_hit({pg(16), 12'h0}, fr(16), 1'b0, 4'h1, "R11");
    do_fill(pg(17), fr(17), 1'b0, 1'b0, 4'h2);
    look_miss({pg(1), 12'h0}, "R11");
    look_hit({pg(2), 12'h0}, fr(2), 1'b0, 4'd2, "R11");

    // R8: full flush
    do_ctl(2'd3, '0, 1'b0, '0);
    for (int i = 2; i < 18; i++) look_miss({pg(i), 12'h0}, "R8");

    // R3: 2MB page, sweep inner pages and offsets
    do_fill(36'h24000, 28'h3400, 1'b1, 1'b0, 4'h5);
    @(negedge clk);
    for (int k = 0; k < 512; k += 37)
      look_hit({36'h24000 | 36'(k), 12'(k * 7)}, 28'h3400, 1'b1, 4'h5, "R3");
    look_hit({36'h241ff, 12'hfff}, 28'h3400, 1'b1, 4'h5, "R3");
    look_miss({36'h24200, 12'h0}, "R3");
    look_miss({36'h23fff, 12'hfff}, "R3");

    // R10: refill overlapping range replaces the slot
    do_fill(36'h24000, 28'h5600, 1'b1, 1'b0, 4'h6);
    look_hit({36'h24123, 12'h456}, 28'h5600, 1'b1, 4'h6, "R10");
    do_fill(36'h24010, 28'h0777, 1'b0, 1'b0, 4'h7);
    look_hit({36'h24010, 12'h0ab}, 28'h0777, 1'b0, 4'h7, "R10");
    look_miss({36'h24011, 12'h0}, "R10");
    do_fill(36'h24010, 28'h0888, 1'b0, 1'b0, 4'h8);
    look_hit({36'h24010, 12'h0ab}, 28'h0888, 1'b0, 4'h8, "R10");

    // R4, R5, R6: contexts and root switches
    do_ctl(2'd3, '0, 1'b0, '0);
    do_ctl(2'd1, 12'h005, 1'b1, '0);
    do_fill(36'h500, 28'h50, 1'b0, 1'b0, 4'h1);
    do_fill(36'h600, 28'h60, 1'b0, 1'b1, 4'h2);
    look_hit({36'h500, 12'h1}, 28'h50, 1'b0, 4'h1, "R4");
    do_ctl(2'd1, 12'h009, 1'b1, '0);
    look_miss({36'h500, 12'h1}, "R4");
    look_hit({36'h600, 12'h2}, 28'h60, 1'b0, 4'h2, "R4");
    do_ctl(2'd1, 12'h005, 1'b1, '0);
    look_hit({36'h500, 12'h3}, 28'h50, 1'b0, 4'h1, "R5");
    do_ctl(2'd1, 12'h009, 1'b0, '0);
    look_hit({36'h600, 12'h4}, 28'h60, 1'b0, 4'h2, "R6");
    do_ctl(2'd1, 12'h005, 1'b1, '0);
    look_miss({36'h500, 12'h3}, "R6");
    look_hit({36'h600, 12'h5}, 28'h60, 1'b0, 4'h2, "R6");

    // R7: page invalidate
    do_ctl(2'd3, '0, 1'b0, '0);
    do_fill(36'h700, 28'h70, 1'b0, 1'b0, 4'h1);
    do_fill(36'h701, 28'h71, 1'b0, 1'b0, 4'h2);
    do_fill(36'h40000, 28'h4000, 1'b1, 1'b0, 4'h3);
    do_fill(36'h800, 28'h80, 1'b0, 1'b1, 4'h4);
    do_ctl(2'd1, 12'h006, 1'b1, '0);
    do_fill(36'h900, 28'h90, 1'b0, 1'b0, 4'h5);
    do_ctl(2'd1, 12'h005, 1'b1, '0);
    do_ctl(2'd2, '0, 1'b0, 36'h700);
    look_miss({36'h700, 12'h0}, "R7");
    look_hit({36'h701, 12'h0}, 28'h71, 1'b0, 4'h2, "R7");
    do_ctl(2'd2, '0, 1'b0, 36'h40003);
    look_miss({36'h40100, 12'h0}, "R7");
    do_ctl(2'd2, '0, 1'b0, 36'h800);
    look_miss({36'h800, 12'h0}, "R7");
    do_ctl(2'd2, '0, 1'b0, 36'h900);
    do_ctl(2'd1, 12'h006, 1'b1, '0);
    look_hit({36'h900, 12'h9}, 28'h90, 1'b0, 4'h5, "R7");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule